// File: doc/BRIEF.md
# Two-Operand Execution Unit

A multicycle controller that fetches one fixed-format 64-bit instruction from a synchronous, word-addressed memory and executes it. Each instruction names one general-purpose register and carries a 32-bit memory field. The unit loads the fetched word into its instruction register. It resolves the first operand from the named register into the accumulator and the second operand from the memory field into the data register. It then applies the operation and retires the instruction.

A 2-bit mode field makes two independent choices. Its upper bit chooses whether the register value is used directly or as a pointer to a memory word. Its lower bit chooses whether the memory field is a direct memory address or a zero-extended immediate. An arithmetic or logic result goes to the accumulator and back into the named register. A store sends the first operand out through the memory write port. The host pulses `start` once per instruction, and `done` marks the retirement. The program counter starts at zero and advances by one word for each instruction.

The memory returns the word addressed in one cycle on `mem_rdata` in the next cycle. A write is taken at the clock edge that ends the cycle in which `mem_we` is high.

Top module: `dox_core`

## Requirements
- R1: After reset, and after a reset applied in the middle of an instruction: busy, done, err and mem_we are 0, acc_o is 0, and mem_addr is 0. The program counter and all registers are cleared, so the next fetch reads address 0.
- R2: The first memory address presented after start is accepted is the program counter. Successive instructions are fetched from successive word addresses.
- R3: Instruction layout: opcode in bits 63:54, mode in 53:52, register number in 51:46 and memory field in 31:0. Bits 45:32 have no effect.
- R4: Mode 01: the first operand is the named register's value, and the second operand is the memory field zero-extended to 64 bits.
- R5: Mode 00: the first operand is the named register's value, and the second operand is the memory word at the address given by the memory field.
- R6: Mode 10: the first operand is the memory word addressed by the low 32 bits of the named register, and the second operand is the memory word at the memory-field address.
- R7: Mode 11: the first operand is read through the register as a pointer, and the second operand is the zero-extended memory field.
- R8: Opcodes 1 ADD, 2 SUB (first minus second), 3 AND, 4 OR, 5 XOR and 6 LOAD (the second operand) each produce a 64-bit result, wrapping modulo 2^64. The result appears on acc_o and is written to the named register.
- R9: Opcode 7 STORE in mode 00 or 10 raises mem_we for exactly one cycle, in the cycle where done is high. In that cycle mem_addr is the memory field and mem_wdata is the first operand. In modes 01 and 11 STORE sets err and writes nothing.
- R10: Any other opcode sets err, still retires with done, and leaves the named register unchanged. Each accepted start clears err.
- R11: done is a single-cycle pulse with busy low. busy is high from the cycle after start is accepted until the instruction retires. A start asserted while busy is ignored.
- R12: Count the edge that samples start as the first edge. done goes high after the sixth rising edge when neither operand reads memory, and each operand memory read adds two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fetching and executing the next instruction |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle retirement pulse |
| err | output | 1 | The last instruction had an unknown opcode or a store to an immediate |
| acc_o | output | 64 | Accumulator contents |
| mem_addr | output | 32 | Word address presented to memory |
| mem_rdata | input | 64 | Memory word for the address presented one cycle earlier |
| mem_wdata | output | 64 | Store data |
| mem_we | output | 1 | Store strobe |

## Verification
A wrong program counter shows up one cycle after start, because mem_addr then carries the fetch address. A wrong decode of the mode bits shows up in the cycle count to done within about ten cycles, since every memory operand adds two cycles, and it also shows as a wrong accumulator value. A register write that was lost, or that should have been suppressed, stays hidden until a later instruction reads that register. For that reason the stimulus keeps threading values through the same registers and re-reads them with an immediate of zero.

// File: rtl/dox_pkg.sv
package dox_pkg;

    // Fixed instruction format
    localparam int ILEN    = 64;
    localparam int OPC_W   = 10;
    localparam int MODE_W  = 2;
    localparam int RSEL_W  = 6;
    localparam int FIELD_W = 32;

    localparam int OPC_LSB   = 54;
    localparam int MODE_LSB  = 52;
    localparam int RSEL_LSB  = 46;
    localparam int FIELD_LSB = 0;

    typedef logic [OPC_W-1:0] opcode_t;

    localparam opcode_t OP_ADD   = 10'd1;
    localparam opcode_t OP_SUB   = 10'd2;
    localparam opcode_t OP_AND   = 10'd3;
    localparam opcode_t OP_OR    = 10'd4;
    localparam opcode_t OP_XOR   = 10'd5;
    localparam opcode_t OP_LOAD  = 10'd6;
    localparam opcode_t OP_STORE = 10'd7;

    typedef struct packed {
        opcode_t              op;
        logic                 ind;   // register operand used as pointer
        logic                 imm;   // memory field is immediate data
        logic [RSEL_W-1:0]    rsel;
        logic [FIELD_W-1:0]   mfield;
    } insn_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FWAIT,
        S_FLOAD,
        S_OPA,
        S_OPA_WAIT,
        S_OPA_LOAD,
        S_OPB,
        S_OPB_WAIT,
        S_OPB_LOAD,
        S_EXEC
    } state_t;

    function automatic insn_t split_word(input logic [ILEN-1:0] w);
        insn_t f;
        f.op     = w[OPC_LSB +: OPC_W];
        f.ind    = w[MODE_LSB + 1];
        f.imm    = w[MODE_LSB];
        f.rsel   = w[RSEL_LSB +: RSEL_W];
        f.mfield = w[FIELD_LSB +: FIELD_W];
        return f;
    endfunction

    function automatic logic op_is_known(input opcode_t op);
        return (op >= OP_ADD) && (op <= OP_STORE);
    endfunction

endpackage

// File: rtl/dox_decode.sv
module dox_decode
    import dox_pkg::*;
(
    input  logic [ILEN-1:0] word,
    output insn_t           insn,
    output logic            op_known,
    output logic            op_store
);
    // Bits between the register number and the memory field carry nothing
    logic unused_gap;
    assign unused_gap = ^word[FIELD_W +: (RSEL_LSB - FIELD_W)];

    always_comb begin
        insn     = split_word(word);
        op_known = op_is_known(insn.op);
        op_store = (insn.op == OP_STORE);
    end
endmodule

// File: rtl/dox_alu.sv
module dox_alu
    import dox_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  opcode_t          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_LOAD: y = b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/dox_regfile.sv
module dox_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREG)-1:0]  raddr,
    output logic [XLEN-1:0]          rdata,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  waddr,
    input  logic [XLEN-1:0]          wdata
);
    localparam int RIDX = $clog2(NREG);

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (waddr == RIDX'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/dox_core.sv
module dox_core
    import dox_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 32,
    parameter int NREG = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [XLEN-1:0] acc_o,
    output logic [AW-1:0]   mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we
);
    localparam int RIDX = $clog2(NREG);

    state_t          state;
    logic [AW-1:0]   pc;
    logic [AW-1:0]   mar;
    logic [ILEN-1:0] ir;
    logic [XLEN-1:0] ac;
    logic [XLEN-1:0] dr;
    logic            done_q;
    logic            err_q;
    logic            we_q;
    logic [XLEN-1:0] wdata_q;

    insn_t           insn;
    logic            op_known;
    logic            op_store;
    logic [XLEN-1:0] rf_rd;
    logic [XLEN-1:0] alu_y;
    logic            rf_we;
    logic            bad_insn;

    dox_decode u_dec (
        .word     (ir),
        .insn     (insn),
        .op_known (op_known),
        .op_store (op_store)
    );

    dox_alu #(.XLEN(XLEN)) u_alu (
        .op (insn.op),
        .a  (ac),
        .b  (dr),
        .y  (alu_y)
    );

    assign bad_insn = !op_known || (op_store && insn.imm);
    assign rf_we    = (state == S_EXEC) && !bad_insn && !op_store;

    dox_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (insn.rsel[RIDX-1:0]),
        .rdata (rf_rd),
        .we    (rf_we),
        .waddr (insn.rsel[RIDX-1:0]),
        .wdata (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            pc      <= '0;
            mar     <= '0;
            ir      <= '0;
            ac      <= '0;
            dr      <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            we_q   <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    mar   <= pc;
                    err_q <= 1'b0;
                    state <= S_FWAIT;
                end
                S_FWAIT: state <= S_FLOAD;
                S_FLOAD: begin
                    ir    <= mem_rdata;
                    pc    <= pc + AW'(1);
                    state <= S_OPA;
                end
                S_OPA: begin
                    if (insn.ind) begin
                        mar   <= rf_rd[AW-1:0];
                        state <= S_OPA_WAIT;
                    end else begin
                        ac    <= rf_rd;
                        state <= S_OPB;
                    end
                end
                S_OPA_WAIT: state <= S_OPA_LOAD;
                S_OPA_LOAD: begin
                    ac    <= mem_rdata;
                    state <= S_OPB;
                end
                S_OPB: begin
                    if (insn.imm) begin
                        dr    <= {{(XLEN-FIELD_W){1'b0}}, insn.mfield};
                        state <= S_EXEC;
                    end else begin
                        mar   <= AW'(insn.mfield);
                        state <= S_OPB_WAIT;
                    end
                end
                S_OPB_WAIT: state <= S_OPB_LOAD;
                S_OPB_LOAD: begin
                    dr    <= mem_rdata;
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                    if (bad_insn) begin
                        err_q <= 1'b1;
                    end else if (op_store) begin
                        mar     <= AW'(insn.mfield);
                        wdata_q <= ac;
                        we_q    <= 1'b1;
                    end else begin
                        ac <= alu_y;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign acc_o     = ac;
    assign mem_addr  = mar;
    assign mem_wdata = wdata_q;
    assign mem_we    = we_q;

    // R11: retirement lasts exactly one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: the unit is idle while it reports retirement
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: a store strobe only accompanies a clean retirement
    p_we_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (done && !err));

    // R10: a flagged instruction never wrote the register file
    p_err_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !$past(rf_we));

    // R2: each fetch advances the program counter by one word
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FLOAD) |=> (pc == $past(pc) + AW'(1)));

endmodule

// File: tb/sim_dox_core.sv
module sim_dox_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        busy, done, err, mem_we;
    logic [63:0] acc_o, mem_rdata, mem_wdata;
    logic [31:0] mem_addr;

    always #5 clk = ~clk;

    dox_core u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .err(err), .acc_o(acc_o), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    // Bench memory: one-cycle registered read, loader port for stimulus
    logic [63:0] mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_a  = '0;
    logic [63:0] ld_d  = '0;

    always @(posedge clk) begin
        if (ld_en)       mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    int n_checks = 0;
    int n_fails  = 0;
    int pc_b     = 0;
    logic        got_we, saw_we;
    logic [31:0] got_addr;
    logic [63:0] got_wdata;

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic logic [63:0] mk(input logic [9:0] op, input logic [1:0] md,
                                       input logic [5:0] rs, input logic [31:0] fld,
                                       input logic [13:0] pad);
        return {op, md, rs, pad, fld};
    endfunction

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'b00:   return "R5";
            2'b01:   return "R4";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // One instruction: place it at pc_b, start, time it, check the outcome
    task automatic run(input logic [63:0] word, input logic [63:0] exp_acc,
                       input logic exp_err, input int exp_lat, input string tag);
        int n;
        poke(pc_b[7:0], word);
        saw_we = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk(mem_addr == 32'(pc_b), {tag, " R2 fetch address"}, 64'(mem_addr), 64'(pc_b));
        chk(busy == 1'b1, {tag, " R11 busy"}, 64'(busy), 64'd1);
        while (!done && n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (mem_we) saw_we = 1'b1;
        end
        got_we = mem_we; got_addr = mem_addr; got_wdata = mem_wdata;
        chk(done == 1'b1, {tag, " R11 done seen"}, 64'(done), 64'd1);
        chk(n == exp_lat, {tag, " R12 latency"}, 64'(n), 64'(exp_lat));
        chk(acc_o == exp_acc, {tag, " acc"}, acc_o, exp_acc);
        chk(err == exp_err, {tag, " R10 err"}, 64'(err), 64'(exp_err));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R11 done one cycle"}, 64'(done), 64'd0);
        pc_b++;
    endtask

    typedef struct packed {
        logic [9:0]  op;
        logic [1:0]  md;
        logic [5:0]  rs;
        logic [31:0] fld;
        logic [13:0] pad;
        logic [63:0] acc;
        logic [7:0]  lat;
    } vec_t;

    // R3 R4 R5 R6 R7 R8 R12: operations threaded through registers r1..r4
    localparam vec_t VT [12] = '{
        '{10'd6, 2'b01, 6'd1, 32'hFFFF_FFFF, 14'h3FFF, 64'h0000_0000_FFFF_FFFF, 8'd6},
        '{10'd1, 2'b01, 6'd1, 32'h0000_0001, 14'h0000, 64'h0000_0001_0000_0000, 8'd6},
        '{10'd6, 2'b00, 6'd2, 32'd200,       14'h1555, 64'h0123_4567_89AB_CDEF, 8'd8},
        '{10'd1, 2'b00, 6'd2, 32'd201,       14'h0000, 64'h0000_0000_0000_0000, 8'd8},
        '{10'd6, 2'b01, 6'd3, 32'd202,       14'h2AAA, 64'h0000_0000_0000_00CA, 8'd6},
        '{10'd1, 2'b10, 6'd3, 32'd200,       14'h0000, 64'h0123_4567_89AB_CDF4, 8'd10},
        '{10'd6, 2'b01, 6'd4, 32'd203,       14'h0001, 64'h0000_0000_0000_00CB, 8'd6},
        '{10'd2, 2'b11, 6'd4, 32'd6,         14'h0000, 64'hFFFF_FFFF_FFFF_FFFD, 8'd8},
        '{10'd3, 2'b01, 6'd3, 32'hF0F0_F0F0, 14'h0000, 64'h0000_0000_80A0_C0F0, 8'd6},
        '{10'd4, 2'b01, 6'd3, 32'h0F0F_0F0F, 14'h3C3C, 64'h0000_0000_8FAF_CFFF, 8'd6},
        '{10'd5, 2'b00, 6'd4, 32'd200,       14'h0000, 64'hFEDC_BA98_7654_3212, 8'd8},
        '{10'd1, 2'b01, 6'd2, 32'd0,         14'h0000, 64'h0000_0000_0000_0000, 8'd6}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(err == 1'b0, "R1 err", 64'(err), 64'd0);
        chk(mem_we == 1'b0, "R1 mem_we", 64'(mem_we), 64'd0);
        chk(acc_o == 64'd0, "R1 acc", acc_o, 64'd0);
        chk(mem_addr == 32'd0, "R1 mem_addr", 64'(mem_addr), 64'd0);

        poke(8'd200, 64'h0123_4567_89AB_CDEF);
        poke(8'd201, 64'hFEDC_BA98_7654_3211);
        poke(8'd202, 64'd5);
        poke(8'd203, 64'd3);

        for (int i = 0; i < 12; i++) begin
            run(mk(VT[i].op, VT[i].md, VT[i].rs, VT[i].fld, VT[i].pad),
                VT[i].acc, 1'b0, int'(VT[i].lat),
                {mode_tag(VT[i].md), " R8 R3 vector"});
        end

        // R9: store through a direct address
        run(mk(10'd7, 2'b00, 6'd4, 32'd210, 14'h0000), 64'hFEDC_BA98_7654_3212,
            1'b0, 8, "R9 store");
        chk(got_we == 1'b1, "R9 store strobe", 64'(got_we), 64'd1);
        chk(got_addr == 32'd210, "R9 store address", 64'(got_addr), 64'd210);
        chk(got_wdata == 64'hFEDC_BA98_7654_3212, "R9 store data", got_wdata,
            64'hFEDC_BA98_7654_3212);
        chk(mem[210] == 64'hFEDC_BA98_7654_3212, "R9 memory written", mem[210],
            64'hFEDC_BA98_7654_3212);

        // R9: store with an immediate field is rejected
        run(mk(10'd7, 2'b01, 6'd4, 32'd5, 14'h0000), 64'hFEDC_BA98_7654_3212,
            1'b1, 6, "R9 store imm");
        chk(saw_we == 1'b0, "R9 no write on imm store", 64'(saw_we), 64'd0);

        // R10: unknown opcode flags err, register r1 keeps its value
        run(mk(10'h3FF, 2'b01, 6'd1, 32'd7, 14'h0000), 64'h0000_0001_0000_0000,
            1'b1, 6, "R10 unknown op");
        run(mk(10'd1, 2'b01, 6'd1, 32'd0, 14'h0000), 64'h0000_0001_0000_0000,
            1'b0, 6, "R10 reg unchanged");

        // R11: a start pulse during an instruction is ignored
        poke(pc_b[7:0], mk(10'd1, 2'b01, 6'd5, 32'd9, 14'h0000));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int w = 0;
            while (!done && w < 40) begin
                @(negedge clk);
                w++;
            end
        end
        chk(acc_o == 64'd9, "R11 first instruction", acc_o, 64'd9);
        repeat (4) begin
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R11 start while busy ignored",
                64'({busy, done}), 64'd0);
        end
        pc_b++;
        run(mk(10'd1, 2'b01, 6'd5, 32'd0, 14'h0000), 64'd9, 1'b0, 6, "R11 single execution");

        // R1: reset in the middle of an instruction
        poke(pc_b[7:0], mk(10'd1, 2'b10, 6'd3, 32'd200, 14'h0000));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0, "R1 busy after mid reset", 64'(busy), 64'd0);
        chk(acc_o == 64'd0, "R1 acc after mid reset", acc_o, 64'd0);
        chk(mem_addr == 32'd0, "R1 mem_addr after mid reset", 64'(mem_addr), 64'd0);
        pc_b = 0;
        run(mk(10'd1, 2'b01, 6'd1, 32'd0, 14'h0000), 64'd0, 1'b0, 6, "R1 registers cleared");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule